// File: doc/BRIEF.md
# Two-Master Priority Bus Arbiter

This block decides which of two masters drives a shared system bus. Master 0 is the processor and has the lowest priority; master 1 is the data transfer controller and has the highest priority. Each master holds a request line high while it wants the bus. The arbiter answers with one grant line per master, and a master owns the bus for as long as its grant stays high.

A higher-priority request never takes the bus away in the middle of a cycle. Each master reports a cycle-end strobe and a lock flag. The bus may change hands only when the current owner's strobe is high and its lock is low. The processor raises lock across the parts of a split access. The transfer controller raises lock inside a phase that must not be broken, and pulses its strobe at each legal release point. While the processor is asleep, the bus may be taken from it at once, whatever its strobe and lock show.

Every handover passes through one clock with no grant asserted. When no master is requesting, the bus rests with the processor.

Top module: `prio_bus_arb`

## Requirements
- R1: After reset, `gnt` is 2'b01: the processor (bit 0) owns the bus.
- R2: At most one bit of `gnt` is high in any cycle.
- R3: When the processor owns the bus and both masters request, the transfer controller (bit 1) is granted once the processor reaches a legal point.
- R4: While the owner's `cyc_end` bit is low, `gnt` does not change. The processor asleep (R6) is the only exception.
- R5: While the owner's `lock` bit is high, `gnt` does not change, even if its `cyc_end` bit is high. The processor asleep (R6) is the only exception.
- R6: While the processor owns the bus and `sleep` is high, it hands the bus to a requesting transfer controller regardless of its `cyc_end` and `lock` bits.
- R7: A handover passes through a clock with `gnt` equal to 0. The clock edge at the legal point clears the grant, and the next edge sets the new owner's grant. No edge ever moves a grant directly from one bit to the other.
- R8: While the transfer controller owns the bus and keeps requesting, it keeps the grant, whatever the processor requests and whatever either strobe shows.
- R9: When the transfer controller drops its request, the bus goes back to the processor at its next legal point (cyc_end bit 1 high, lock bit 1 low). This happens even if the processor is not requesting. While nobody requests, the processor keeps the grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | N_MST | Bus request per master; bit 0 is the processor, the highest bit is the transfer controller |
| cyc_end | input | N_MST | Per master: high when this clock ends a bus cycle or phase at which the bus may change hands |
| lock | input | N_MST | Per master: high while the current cycle belongs to an access or phase that must not be split |
| sleep | input | 1 | The processor is in sleep mode |
| gnt | output | N_MST | Grant per master, registered; at most one bit is high |

## Verification
The bench builds the block with its default `N_MST = 2`, which is the two-master arrangement described above. With only two masters, every ownership path can be reached in a short directed run: processor to controller at a boundary, processor to controller through sleep, and controller back to the processor with and without a processor request. The bench also holds inputs so that a strobe is high while lock is high, which separates the effect of each gating input on its own.

// File: rtl/arb_pkg.sv
package arb_pkg;

    // Arbiter phase: a master owns the bus, or a one-clock gap during a handover
    typedef enum logic {
        PH_OWN = 1'b0,
        PH_GAP = 1'b1
    } arb_phase_e;

endpackage

// File: rtl/arb_prio_pick.sv
// Fixed-priority selector: the highest-index requester wins.
module arb_prio_pick #(
    parameter int N_MST = 2,
    parameter int IDX_W = 1
) (
    input  logic [N_MST-1:0] req,
    output logic [IDX_W-1:0] best,
    output logic             any
);
    always_comb begin
        best = '0;
        any  = 1'b0;
        for (int i = 0; i < N_MST; i++) begin
            if (req[i]) begin
                best = IDX_W'(i);
                any  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/arb_release_gate.sv
// Tells whether the current owner is at a point where the bus may change hands.
module arb_release_gate #(
    parameter int N_MST = 2,
    parameter int IDX_W = 1
) (
    input  logic [N_MST-1:0] cyc_end,
    input  logic [N_MST-1:0] lock,
    input  logic             sleep,
    input  logic [IDX_W-1:0] owner,
    output logic             allow
);
    logic [N_MST-1:0] point;

    for (genvar i = 0; i < N_MST; i++) begin : g_point
        if (i == 0) begin : g_cpu
            // the processor can also let go at once while it sleeps
            assign point[i] = (cyc_end[i] & ~lock[i]) | sleep;
        end else begin : g_other
            assign point[i] = cyc_end[i] & ~lock[i];
        end
    end

    assign allow = point[owner];
endmodule

// File: rtl/prio_bus_arb.sv
module prio_bus_arb
    import arb_pkg::*;
#(
    parameter int N_MST = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_MST-1:0] req,
    input  logic [N_MST-1:0] cyc_end,
    input  logic [N_MST-1:0] lock,
    input  logic             sleep,
    output logic [N_MST-1:0] gnt
);
    localparam int IDX_W = (N_MST > 1) ? $clog2(N_MST) : 1;

    typedef struct packed {
        arb_phase_e       phase;
        logic [IDX_W-1:0] owner;
        logic [N_MST-1:0] gnt;
    } arb_state_t;

    arb_state_t       st_d, st_q;
    logic [IDX_W-1:0] best;
    logic             any_req;
    logic             allow;
    logic [IDX_W-1:0] target;

    arb_prio_pick #(.N_MST(N_MST), .IDX_W(IDX_W)) i_pick (
        .req  (req),
        .best (best),
        .any  (any_req)
    );

    arb_release_gate #(.N_MST(N_MST), .IDX_W(IDX_W)) i_gate (
        .cyc_end (cyc_end),
        .lock    (lock),
        .sleep   (sleep),
        .owner   (st_q.owner),
        .allow   (allow)
    );

    // the bus rests with master 0 when nobody asks for it
    assign target = any_req ? best : '0;

    always_comb begin
        st_d = st_q;
        if (st_q.phase == PH_GAP) begin
            st_d.phase            = PH_OWN;
            st_d.gnt              = '0;
            st_d.gnt[st_q.owner]  = 1'b1;
        end else if ((target != st_q.owner) && allow) begin
            st_d.phase = PH_GAP;
            st_d.owner = target;
            st_d.gnt   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= PH_OWN;
            st_q.owner <= '0;
            st_q.gnt   <= N_MST'(1);
        end else begin
            st_q <= st_d;
        end
    end

    assign gnt = st_q.gnt;

    // R2: never two grants at once
    p_one_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    // R4: owner not at a cycle end keeps the bus (sleeping processor excepted)
    p_hold_mid_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((|gnt) && ((gnt & cyc_end) == '0) && !(gnt[0] && sleep)) |=> (gnt == $past(gnt)));

    // R5: a locked owner keeps the bus (sleeping processor excepted)
    p_hold_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (((gnt & lock) != '0) && !(gnt[0] && sleep)) |=> (gnt == $past(gnt)));

    // R7: a grant is only ever kept or cleared, never moved directly
    p_gap_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|gnt) |=> ((gnt == $past(gnt)) || (gnt == '0)));

    // R7: an empty grant is filled on the next clock
    p_gap_short_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt == '0) |=> (|gnt));

    // R8: the top master keeps the bus while it requests
    p_top_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt[N_MST-1] && req[N_MST-1]) |=> gnt[N_MST-1]);

endmodule

// File: tb/test_prio_bus_arb.sv
module test_prio_bus_arb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] req = '0, cyc_end = '0, lock = '0;
    logic       sleep = 1'b0;
    logic [1:0] gnt;

    int checks = 0;
    int errors = 0;
    bit driver_done = 1'b0;

    typedef struct {
        logic [1:0] exp;
        string      tag;
    } exp_item_t;

    exp_item_t sb_q[$];

    always #5 clk = ~clk;

    prio_bus_arb #(.N_MST(2)) i_prio_bus_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req),
        .cyc_end (cyc_end),
        .lock    (lock),
        .sleep   (sleep),
        .gnt     (gnt)
    );

    task automatic check(input logic [1:0] act, input logic [1:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: gnt=%b expected %b", tag, act, exp);
        end
    endtask

    // driver: set inputs for the next edge and push the grant expected after it
    task automatic step(input logic [1:0] r, input logic [1:0] ce, input logic [1:0] lk,
                        input logic sl, input logic [1:0] exp, input string tag);
        @(negedge clk);
        req = r; cyc_end = ce; lock = lk; sleep = sl;
        sb_q.push_back('{exp, tag});
    endtask

    // monitor: compare away from the edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb_q.size() > 0) begin
                exp_item_t it;
                it = sb_q.pop_front();
                check(gnt, it.exp, it.tag);
                checks++;
                if (gnt[0] && gnt[1]) begin
                    errors++;
                    $display("FAIL R2: gnt=%b expected at most one bit", gnt);
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(gnt, 2'b01, "R1 reset owner");
        rst_n = 1'b1;
        @(negedge clk);
        check(gnt, 2'b01, "R1 after release");

        // processor owns; controller asks mid-cycle, then at a boundary
        step(2'b11, 2'b00, 2'b00, 1'b0, 2'b01, "R4 no boundary");
        step(2'b11, 2'b00, 2'b00, 1'b0, 2'b01, "R4 still no boundary");
        step(2'b11, 2'b01, 2'b00, 1'b0, 2'b00, "R7 gap after legal point");
        step(2'b11, 2'b00, 2'b00, 1'b0, 2'b10, "R3 controller granted");
        // controller keeps the bus while requesting
        step(2'b11, 2'b11, 2'b00, 1'b0, 2'b10, "R8 kept with strobes high");
        step(2'b01, 2'b00, 2'b00, 1'b0, 2'b10, "R9 released only at phase end");
        step(2'b01, 2'b10, 2'b10, 1'b0, 2'b10, "R5 controller locked");
        step(2'b01, 2'b10, 2'b00, 1'b0, 2'b00, "R9 release gap");
        step(2'b01, 2'b00, 2'b00, 1'b0, 2'b01, "R9 back to processor");
        // processor locked across a split access
        step(2'b11, 2'b01, 2'b01, 1'b0, 2'b01, "R5 processor locked");
        step(2'b11, 2'b01, 2'b01, 1'b0, 2'b01, "R5 processor still locked");
        // sleep overrides boundary and lock
        step(2'b11, 2'b00, 2'b01, 1'b1, 2'b00, "R6 sleep hands over");
        step(2'b10, 2'b00, 2'b00, 1'b1, 2'b10, "R6 controller granted");
        step(2'b10, 2'b10, 2'b00, 1'b1, 2'b10, "R8 sleep does not move controller");
        // controller releases with nobody else asking
        step(2'b00, 2'b10, 2'b00, 1'b0, 2'b00, "R9 idle release gap");
        step(2'b00, 2'b00, 2'b00, 1'b0, 2'b01, "R9 default to processor");
        step(2'b00, 2'b01, 2'b00, 1'b0, 2'b01, "R9 processor parks");
        step(2'b00, 2'b01, 2'b00, 1'b1, 2'b01, "R9 parks while asleep");
        step(2'b00, 2'b00, 2'b00, 1'b0, 2'b01, "R9 parked");
        @(negedge clk);
        @(negedge clk);
        driver_done = 1'b1;
    end

    initial begin
        fork
            wait (driver_done && sb_q.size() == 0);
            begin
                #2000000;
                errors++;
                checks++;
                $display("FAIL watchdog: done=%0d expected 1", driver_done);
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule